// File: doc/BRIEF.md
# Partitioned Compare with Shifted Mask

This unit compares two 64-bit operands lane by lane. The operands are split into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Each lane gives one result bit, so one operation gives an 8-, 4- or 2-bit mask. The unit then shifts that mask left into a 64-bit integer result. The shift is a 3-bit operand multiplied by the mask width, so software can OR the results of several compares into one packed word.

There are four operation classes:

- a signed condition compare;
- an unsigned condition compare;
- a dual-pattern equality test, which matches each lane against either of two 32-bit patterns held in the second operand;
- an exclusive unsigned range test, whose two bounds are the two 32-bit halves of the second operand.

The result is registered and appears one cycle after the request, together with its valid flag.

Top module: `psc_top`

## Requirements
- R1: `lsz_i` picks the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, and 2 or 3 give 32-bit lanes. Mask bit i belongs to lane i, and lane 0 is the least significant lane. The mask is exactly as wide as the lane count.
- R2: When `cls_i`=0 (signed compare), each lane is compared as two's complement values. The `cc_i` codes are 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT and 5 GE, each meaning a-lane OP b-lane.
- R3: When `cls_i`=1 (unsigned compare), the same `cc_i` codes apply, and each lane is compared as an unsigned value.
- R4: For `cls_i` 0 or 1, the `cc_i` codes 6 and 7 give an all-zero mask.
- R5: When `cls_i`=2 (dual equality), a lane bit is set if the a-lane equals the matching lane of `{b[63:32],b[63:32]}` or the matching lane of `{b[31:0],b[31:0]}`. `cc_i` is ignored.
- R6: When `cls_i`=3 (range), a lane bit is set when low < a-lane < high, compared as unsigned values. The low bound is the lane of `{b[63:32],b[63:32]}` and the high bound is the lane of `{b[31:0],b[31:0]}`. Both ends are exclusive, so equal halves give a zero mask.
- R7: The mask is placed at bit `sh_i` × (lane count). All result bits outside the placed mask are zero.
- R8: `valid_o` and `result_o` update on the clock edge after the edge that samples `valid_i`=1, so the latency is one cycle.
- R9: Reset (`rst_n` low, sampled at the clock edge) clears `valid_o` and `result_o`. `result_o` is zero whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| cls_i | input | 2 | Operation class |
| cc_i | input | 3 | Condition code for classes 0 and 1 |
| lsz_i | input | 2 | Lane width select |
| sh_i | input | 3 | Mask position, counted in units of the mask width |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand, or the pair of patterns or bounds |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Placed mask |

## Verification
The assertions check the following on every cycle:

- the one-cycle valid latency;
- that the output is zero while idle;
- that no result bit falls outside the window set by the lane count and shift;
- that the raw mask never has bits above the lane count.

They also check three fixed outcomes: reserved condition codes give zero, equal range bounds give zero, and an operand equal to its own replicated pattern matches in every lane.

Only the bench's scenarios can show that each lane's comparison is correct. This covers signed against unsigned ordering at the lane boundaries, the exclusive range ends, and which half feeds which bound. The bench checks these against its own reference for every class, lane width and shift value.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam logic [1:0] CLS_SCMP = 2'd0;
  localparam logic [1:0] CLS_UCMP = 2'd1;
  localparam logic [1:0] CLS_DEQ  = 2'd2;
  localparam logic [1:0] CLS_RNG  = 2'd3;

  localparam logic [2:0] CC_EQ = 3'd0;
  localparam logic [2:0] CC_NE = 3'd1;
  localparam logic [2:0] CC_LT = 3'd2;
  localparam logic [2:0] CC_LE = 3'd3;
  localparam logic [2:0] CC_GT = 3'd4;
  localparam logic [2:0] CC_GE = 3'd5;

  // Turns a less-than flag and an equal flag into the chosen condition.
  function automatic logic cond_eval(input logic lt, input logic eq, input logic [2:0] cc);
    logic r;
    case (cc)
      CC_EQ:   r = eq;
      CC_NE:   r = !eq;
      CC_LT:   r = lt;
      CC_LE:   r = lt | eq;
      CC_GT:   r = !(lt | eq);
      CC_GE:   r = !lt;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Index of the lane bank: code 3 is an alias for the widest lanes.
  function automatic logic [1:0] size_index(input logic [1:0] lsz);
    return (lsz == 2'd3) ? 2'd2 : lsz;
  endfunction
endpackage

// File: rtl/psc_lane.sv
module psc_lane
  import psc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] pat_hi,
  input  logic [W-1:0] pat_lo,
  input  logic [1:0]   cls,
  input  logic [2:0]   cc,
  output logic         hit
);
  logic eq, slt, ult, deq_hit, rng_hit;

  always_comb begin
    eq      = (a == b);
    slt     = ($signed(a) < $signed(b));
    ult     = (a < b);
    deq_hit = (a == pat_hi) || (a == pat_lo);
    rng_hit = (a > pat_hi) && (a < pat_lo);
    case (cls)
      CLS_SCMP: hit = cond_eval(slt, eq, cc);
      CLS_UCMP: hit = cond_eval(ult, eq, cc);
      CLS_DEQ:  hit = deq_hit;
      default:  hit = rng_hit;
    endcase
  end
endmodule

// File: rtl/psc_bank.sv
module psc_bank #(
  parameter int DW = 64,
  parameter int LW = 8,
  parameter int MW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    cls,
  input  logic [2:0]    cc,
  output logic [MW-1:0] mask
);
  localparam int NL   = DW / LW;
  localparam int HALF = DW / 2;

  logic [DW-1:0] pat_hi_rep, pat_lo_rep;
  assign pat_hi_rep = {2{b[DW-1:HALF]}};
  assign pat_lo_rep = {2{b[HALF-1:0]}};

  for (genvar i = 0; i < MW; i++) begin : g_lane
    if (i < NL) begin : g_live
      psc_lane #(.W(LW)) u_lane (
        .a      (a[i*LW +: LW]),
        .b      (b[i*LW +: LW]),
        .pat_hi (pat_hi_rep[i*LW +: LW]),
        .pat_lo (pat_lo_rep[i*LW +: LW]),
        .cls    (cls),
        .cc     (cc),
        .hit    (mask[i])
      );
    end else begin : g_pad
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/psc_place.sv
module psc_place #(
  parameter int DW  = 64,
  parameter int MW  = 8,
  parameter int SHW = 3,
  parameter int CW  = 4
) (
  input  logic [MW-1:0]  mask,
  input  logic [CW-1:0]  lanes,
  input  logic [SHW-1:0] sh,
  output logic [DW-1:0]  placed
);
  localparam int AW = SHW + CW;

  logic [AW-1:0] amount;
  logic [DW-1:0] wide;

  always_comb begin
    amount = AW'(sh) * AW'(lanes);
    wide   = '0;
    wide[MW-1:0] = mask;
    placed = wide << amount;
  end
endmodule

// File: rtl/psc_top.sv
module psc_top
  import psc_pkg::*;
#(
  parameter int DW      = 64,
  parameter int BASE_LW = 8,
  parameter int SHW     = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic [1:0]     cls_i,
  input  logic [2:0]     cc_i,
  input  logic [1:0]     lsz_i,
  input  logic [SHW-1:0] sh_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic           valid_o,
  output logic [DW-1:0]  result_o
);
  localparam int NSZ = 3;
  localparam int MW  = DW / BASE_LW;
  localparam int CW  = $clog2(MW) + 1;

  logic [NSZ-1:0][MW-1:0] bank_mask;
  logic [NSZ-1:0]         size_oh;
  logic [MW-1:0]          raw_mask;
  logic [CW-1:0]          lane_cnt;
  logic [DW-1:0]          placed;
  logic [1:0]             sidx;

  for (genvar k = 0; k < NSZ; k++) begin : g_bank
    psc_bank #(.DW(DW), .LW(BASE_LW << k), .MW(MW)) u_bank (
      .a    (a_i),
      .b    (b_i),
      .cls  (cls_i),
      .cc   (cc_i),
      .mask (bank_mask[k])
    );
  end

  always_comb begin
    sidx     = size_index(lsz_i);
    size_oh  = NSZ'(1) << sidx;
    lane_cnt = CW'(MW >> sidx);
    raw_mask = '0;
    for (int k = 0; k < NSZ; k++)
      raw_mask = raw_mask | (bank_mask[k] & {MW{size_oh[k]}});
  end

  psc_place #(.DW(DW), .MW(MW), .SHW(SHW), .CW(CW)) u_place (
    .mask   (raw_mask),
    .lanes  (lane_cnt),
    .sh     (sh_i),
    .placed (placed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= valid_i;
      result_o <= valid_i ? placed : '0;
    end
  end
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
  parameter int DW  = 64,
  parameter int MW  = 8,
  parameter int SHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_i,
  input logic [1:0]     cls_i,
  input logic [2:0]     cc_i,
  input logic [1:0]     lsz_i,
  input logic [SHW-1:0] sh_i,
  input logic [DW-1:0]  a_i,
  input logic [DW-1:0]  b_i,
  input logic           valid_o,
  input logic [DW-1:0]  result_o,
  input logic [MW-1:0]  raw_mask,
  input logic [2:0]     size_oh
);
  logic [DW-1:0] lanes_ones, win;
  logic [MW-1:0] lane_lim;
  int            cnt;

  always_comb begin
    cnt        = MW >> ((lsz_i == 2'd3) ? 2 : int'(lsz_i));
    lanes_ones = (DW'(1) << cnt) - DW'(1);
    win        = lanes_ones << (int'(sh_i) * cnt);
    lane_lim   = lanes_ones[MW-1:0];
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) valid_i |=> valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !valid_i |=> !valid_o); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> (result_o == '0)); // R9
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) valid_i |=> ((result_o & ~$past(win)) == '0)); // R7
  AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(size_oh) && ((raw_mask & ~lane_lim) == '0)); // R1
  AST_RSVD_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !cls_i[1] && (cc_i >= 3'd6)) |=> (result_o == '0)); // R4
  AST_RANGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (cls_i == 2'd3) && (b_i[DW-1:DW/2] == b_i[DW/2-1:0])) |=> (result_o == '0)); // R6
  AST_DEQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (cls_i == 2'd2) && (a_i == {2{b_i[DW-1:DW/2]}})) |=> (result_o == $past(win))); // R5
endmodule

bind psc_top psc_chk #(.DW(DW), .MW(MW), .SHW(SHW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .cls_i    (cls_i),
  .cc_i     (cc_i),
  .lsz_i    (lsz_i),
  .sh_i     (sh_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .raw_mask (raw_mask),
  .size_oh  (size_oh)
);

// File: tb/sim_psc_top.sv
module sim_psc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  cls_i = '0, lsz_i = '0;
  logic [2:0]  cc_i = '0, sh_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  psc_top u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cls_i(cls_i), .cc_i(cc_i),
    .lsz_i(lsz_i), .sh_i(sh_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  // Layout: cls[201:200] cc[199:197] lsz[196:195] sh[194:192] a[191:128] b[127:64] exp[63:0]
  localparam logic [201:0] VEC [8] = '{
    {2'd0, 3'd2, 2'd0, 3'd0, 64'h8000_0000_0000_00FF, 64'h0, 64'h81},                                  // R2 signed LT
    {2'd1, 3'd4, 2'd0, 3'd1, 64'h8000_0000_0000_00FF, 64'h0, 64'h8100},                                // R3 unsigned GT
    {2'd2, 3'd0, 2'd1, 3'd2, 64'h1111_4444_0000_2222, 64'h1111_2222_3333_4444, 64'hD00},               // R5 dual equal
    {2'd3, 3'd0, 2'd2, 3'd3, 64'h0000_001F_0000_0010, 64'h0000_0010_0000_0020, 64'h80},                // R6 range edge
    {2'd0, 3'd5, 2'd2, 3'd7, 64'hFFFF_FFFF_0000_0005, 64'h5, 64'h4000},                                // R2 signed GE
    {2'd1, 3'd6, 2'd0, 3'd0, 64'h1234, 64'h1234, 64'h0},                                               // R4 reserved cc
    {2'd1, 3'd1, 2'd3, 3'd0, 64'h0000_0001_0000_0000, 64'h0, 64'h2},                                   // R1 code 3 as 32-bit
    {2'd0, 3'd3, 2'd0, 3'd7, 64'h0, 64'h0101_0101_0101_0101, 64'hFF00_0000_0000_0000}                  // R7 top position
  };

  function automatic bit pick(input longint x, input longint y, input logic [2:0] cc);
    case (cc)
      3'd0: return x == y;
      3'd1: return x != y;
      3'd2: return x < y;
      3'd3: return x <= y;
      3'd4: return x > y;
      3'd5: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] ref_calc(input logic [1:0] cls, input logic [2:0] cc,
      input logic [1:0] lsz, input logic [2:0] sh, input logic [63:0] a, input logic [63:0] b);
    int w, n;
    logic [63:0] m, r;
    longint x, y, sx, sy, lo, hi;
    bit hit;
    w = (lsz == 2'd0) ? 8 : (lsz == 2'd1) ? 16 : 32;
    n = 64 / w;
    m = (64'd1 << w) - 64'd1;
    r = '0;
    for (int l = 0; l < n; l++) begin
      x  = longint'((a >> (l * w)) & m);
      y  = longint'((b >> (l * w)) & m);
      sx = (x >= (longint'(1) << (w - 1))) ? x - (longint'(1) << w) : x;
      sy = (y >= (longint'(1) << (w - 1))) ? y - (longint'(1) << w) : y;
      lo = longint'(({32'd0, b[63:32]} >> ((l * w) % 32)) & m);
      hi = longint'(({32'd0, b[31:0]} >> ((l * w) % 32)) & m);
      case (cls)
        2'd0: hit = pick(sx, sy, cc);
        2'd1: hit = pick(x, y, cc);
        2'd2: hit = (x == lo) || (x == hi);
        default: hit = (x > lo) && (x < hi);
      endcase
      if (hit) r[l] = 1'b1;
    end
    return r << (int'(sh) * n);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] cls, input logic [2:0] cc, input logic [1:0] lsz,
      input logic [2:0] sh, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] exp, input string tag);
    @(negedge clk);
    cls_i = cls; cc_i = cc; lsz_i = lsz; sh_i = sh; a_i = a; b_i = b; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, result_o, exp);
    check("R8 valid after one cycle", {63'd0, valid_o}, 64'd1);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", {63'd0, valid_o}, 64'd0);
    check("R9 reset result", result_o, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed table
    for (int i = 0; i < 8; i++)
      run_op(VEC[i][201:200], VEC[i][199:197], VEC[i][196:195], VEC[i][194:192],
             VEC[i][191:128], VEC[i][127:64], VEC[i][63:0], "R1 R2 R3 R4 R5 R6 R7 table");

    // Every class, lane width and shift value against the reference
    for (int rep = 0; rep < 2; rep++)
      for (int c = 0; c < 4; c++)
        for (int z = 0; z < 4; z++)
          for (int s = 0; s < 8; s++) begin
            logic [63:0] ra, rb;
            logic [2:0] rc;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            rc = 3'($urandom_range(0, 7));
            if (rep == 1 && c == 2) ra = {rb[63:32], rb[31:0] ^ 32'h00FF_0000};
            run_op(2'(c), rc, 2'(z), 3'(s), ra, rb,
                   ref_calc(2'(c), rc, 2'(z), 3'(s), ra, rb), "R2 R3 R5 R6 R7 random");
          end

    // R9: idle cycle leaves zero output
    @(negedge clk);
    check("R9 idle result", result_o, 64'd0);
    check("R9 idle valid", {63'd0, valid_o}, 64'd0);

    // R8: nothing appears before the capturing edge
    @(negedge clk);
    cls_i = 2'd1; cc_i = 3'd1; lsz_i = 2'd0; sh_i = 3'd0; a_i = 64'hFF; b_i = 64'h0; valid_i = 1'b1;
    #1;
    check("R8 no early result", result_o, 64'd0);
    @(negedge clk);
    check("R8 result after edge", result_o, 64'h1);

    // R9: reset clears an in-flight request
    rst_n = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 reset clears result", result_o, 64'd0);
    check("R9 reset clears valid", {63'd0, valid_o}, 64'd0);
    rst_n = 1'b1;

    // R5: cc ignored in dual-equal; R6: equal bounds give empty range
    run_op(2'd2, 3'd7, 2'd0, 3'd0, 64'h0000_0000_AABB_CCDD, 64'h1122_3344_AABB_CCDD,
           64'h0F, "R5 cc ignored");
    run_op(2'd3, 3'd0, 2'd1, 3'd5, 64'h0005_0005_0005_0005, 64'h0005_0005_0005_0005,
           64'h0, "R6 exclusive bounds");
    run_op(2'd1, 3'd7, 2'd2, 3'd7, 64'h1, 64'h1, 64'h0, "R4 cc 7 zero");

    finish_run();
  end
endmodule